// File: doc/BRIEF.md
# Transfer CRC-16 Framing Unit

This unit builds the 16-bit check value that guards byte transfers between a bus master and a small memory device. It follows three command flows (writing the scratchpad, reading the scratchpad, and an extended memory read that runs page by page). For each flow it decides which bytes enter the check register, when the register is zeroed, and when the finished value may be sent. The bit-level bus engine feeds it one byte at a time, with a tag saying what kind of byte it is and the scratchpad offset the byte belongs to.

A command-start pulse carries the command code, which is folded into a freshly zeroed register. Later bytes arrive on a single-cycle valid strobe. The unit never applies back-pressure on this side: every strobed byte is taken or ignored in its own cycle. The finished value leaves as a valid/ready byte stream, in ones' complement, low-order byte first. The offered byte stays stable while the consumer holds ready low, and it advances only on a cycle where valid and ready are both high. A plain crc_ready flag marks that the check value is final. It stays high after both bytes have gone, until the next command start or page restart.

Top module: `xcrc_framer`

## Requirements
- R1: The register is 16 bits, starts at zero and is updated LSB first through a reflected shift with feedback constant 0xA001 (polynomial x^16 + x^15 + x^2 + 1). The streamed bytes are the ones' complement of the register: first bits 7..0, then bits 15..8.
- R2: A cmd_start pulse zeroes the register and folds cmd_code into it. It drops crc_ready and any pending output in the next cycle, whatever the previous flow was doing, and it takes precedence over a byte or page restart in the same cycle.
- R3: Under command code 0x0F (scratchpad write), bytes tagged address (in_kind 1) and data (in_kind 3) are folded in. Bytes tagged status (2) or command (0) have no effect.
- R4: In scratchpad write, crc_ready rises in the cycle after a data byte tagged with offset 31 is taken, for any starting offset. It stays low before that byte.
- R5: Under command code 0xAA (scratchpad read), address, status and data bytes are folded in. crc_ready rises after the data byte at offset 31.
- R6: Under command code 0xA5 (extended read), the first page folds in address and data bytes. crc_ready rises after the data byte at offset 31.
- R7: In extended read, a page_restart pulse zeroes the register and drops crc_ready. From then on until the next command, address bytes are ignored and only data bytes are folded in.
- R8: page_restart has no effect in the scratchpad write and read flows.
- R9: While crc_ready is high, strobed bytes have no effect on the register.
- R10: out_valid rises together with crc_ready and offers the low byte. The byte is held while out_ready is low, the high byte follows the first handshake, and out_valid falls after the second handshake while crc_ready stays high.
- R11: Any other command code makes every byte ignored, and crc_ready never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Start of a new command, one cycle |
| cmd_code | input | 8 | Command code, sampled with cmd_start |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Byte value |
| in_kind | input | 2 | Byte tag: 0 command, 1 address, 2 status, 3 data |
| sp_offset | input | 5 | Scratchpad offset of the strobed byte |
| page_restart | input | 1 | Start of a later page in extended read |
| crc_ready | output | 1 | Check value is final |
| out_valid | output | 1 | A check byte is offered |
| out_ready | input | 1 | Consumer takes the offered byte |
| out_byte | output | 8 | Inverted check byte, low first |

## Verification
The scratchpad write and read flows are swept over every starting offset, each with a mixed byte pattern. This separates a correct end-of-scratchpad detection from one tied to the start offset or the byte count. Stray status bytes, command-tagged bytes, page restarts and bytes after completion are injected into these flows, and the final value shows whether they were wrongly folded in. Extended read runs three pages, each with an address byte sent on the later pages, to tell per-page clearing and address masking apart from plain accumulation. Back-pressure on the output, an unknown command and an abort in mid-flow check the byte order, the holding of the offered byte and the clearing priority.

// File: rtl/xcrc_pkg.sv
package xcrc_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_STAT = 2'd2,
    KIND_DATA = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    FLOW_IDLE = 2'd0,
    FLOW_WR   = 2'd1,
    FLOW_RD   = 2'd2,
    FLOW_XR   = 2'd3
  } flow_e;
endpackage

// File: rtl/xcrc_step.sv
module xcrc_step #(
  parameter int CW = 16,
  parameter int BW = 8,
  parameter logic [CW-1:0] POLY = 16'hA001
) (
  input  logic [CW-1:0] crc_in,
  input  logic [BW-1:0] din,
  output logic [CW-1:0] crc_out
);
  logic [CW-1:0] chain [0:BW];

  assign chain[0] = crc_in;

  for (genvar g = 0; g < BW; g++) begin : g_bit
    logic fb;
    assign fb = chain[g][0] ^ din[g];
    assign chain[g+1] = fb ? ((chain[g] >> 1) ^ POLY) : (chain[g] >> 1);
  end

  assign crc_out = chain[BW];
endmodule

// File: rtl/xcrc_cover.sv
module xcrc_cover
  import xcrc_pkg::*;
#(
  parameter int BW = 8,
  parameter int OFS_W = 5,
  parameter logic [BW-1:0] CODE_WR = 8'h0F,
  parameter logic [BW-1:0] CODE_RD = 8'hAA,
  parameter logic [BW-1:0] CODE_XR = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [BW-1:0]    cmd_code,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic [OFS_W-1:0] sp_offset,
  input  logic             page_restart,
  input  logic             hold,
  output logic             take,
  output logic             page_end,
  output logic             xr_clear
);
  localparam logic [OFS_W-1:0] LAST_OFS = {OFS_W{1'b1}};

  flow_e flow_q, flow_new;
  logic  later_q;
  logic  covered;

  always_comb begin
    if (cmd_code == CODE_WR)      flow_new = FLOW_WR;
    else if (cmd_code == CODE_RD) flow_new = FLOW_RD;
    else if (cmd_code == CODE_XR) flow_new = FLOW_XR;
    else                          flow_new = FLOW_IDLE;
  end

  always_comb begin
    case (flow_q)
      FLOW_WR: covered = (in_kind == KIND_ADDR) || (in_kind == KIND_DATA);
      FLOW_RD: covered = (in_kind == KIND_ADDR) || (in_kind == KIND_STAT) ||
                         (in_kind == KIND_DATA);
      FLOW_XR: covered = (in_kind == KIND_DATA) ||
                         ((in_kind == KIND_ADDR) && !later_q);
      default: covered = 1'b0;
    endcase
  end

  assign xr_clear = page_restart && (flow_q == FLOW_XR) && !cmd_start;
  assign take     = in_valid && covered && !hold && !cmd_start && !xr_clear;
  assign page_end = take && (in_kind == KIND_DATA) && (sp_offset == LAST_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_q  <= FLOW_IDLE;
      later_q <= 1'b0;
    end else if (cmd_start) begin
      flow_q  <= flow_new;
      later_q <= 1'b0;
    end else if (xr_clear) begin
      later_q <= 1'b1;
    end
  end
endmodule

// File: rtl/xcrc_tx.sv
module xcrc_tx (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic arm,
  input  logic out_ready,
  output logic done,
  output logic out_valid,
  output logic sel_hi
);
  typedef enum logic [1:0] {TX_IDLE, TX_LO, TX_HI} tx_e;
  tx_e ph_q;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= TX_IDLE;
      done_q <= 1'b0;
    end else if (clear) begin
      ph_q   <= TX_IDLE;
      done_q <= 1'b0;
    end else if (arm) begin
      ph_q   <= TX_LO;
      done_q <= 1'b1;
    end else if (out_ready) begin
      case (ph_q)
        TX_LO:   ph_q <= TX_HI;
        TX_HI:   ph_q <= TX_IDLE;
        default: ph_q <= TX_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign out_valid = (ph_q != TX_IDLE);
  assign sel_hi    = (ph_q == TX_HI);
endmodule

// File: rtl/xcrc_framer.sv
module xcrc_framer #(
  parameter int BW = 8,
  parameter int CW = 16,
  parameter int SP_DEPTH = 32,
  parameter logic [CW-1:0] POLY = 16'hA001,
  parameter logic [BW-1:0] CODE_WR = 8'h0F,
  parameter logic [BW-1:0] CODE_RD = 8'hAA,
  parameter logic [BW-1:0] CODE_XR = 8'hA5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_start,
  input  logic [BW-1:0]               cmd_code,
  input  logic                        in_valid,
  input  logic [BW-1:0]               in_byte,
  input  logic [1:0]                  in_kind,
  input  logic [$clog2(SP_DEPTH)-1:0] sp_offset,
  input  logic                        page_restart,
  output logic                        crc_ready,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [BW-1:0]               out_byte
);
  localparam int OFS_W = $clog2(SP_DEPTH);

  logic [CW-1:0] crc_q, step_c, step_o;
  logic [BW-1:0] step_b;
  logic take, page_end, xr_clear, sel_hi;

  assign step_c = cmd_start ? '0 : crc_q;
  assign step_b = cmd_start ? cmd_code : in_byte;

  xcrc_step #(.CW(CW), .BW(BW), .POLY(POLY)) i_step (
    .crc_in(step_c), .din(step_b), .crc_out(step_o)
  );

  xcrc_cover #(
    .BW(BW), .OFS_W(OFS_W),
    .CODE_WR(CODE_WR), .CODE_RD(CODE_RD), .CODE_XR(CODE_XR)
  ) i_cover (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_code(cmd_code),
    .in_valid(in_valid), .in_kind(in_kind), .sp_offset(sp_offset),
    .page_restart(page_restart), .hold(crc_ready),
    .take(take), .page_end(page_end), .xr_clear(xr_clear)
  );

  xcrc_tx i_tx (
    .clk(clk), .rst_n(rst_n), .clear(cmd_start | xr_clear), .arm(page_end),
    .out_ready(out_ready), .done(crc_ready), .out_valid(out_valid),
    .sel_hi(sel_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= '0;
    else if (cmd_start) crc_q <= step_o;
    else if (xr_clear)  crc_q <= '0;
    else if (take)      crc_q <= step_o;
  end

  assign out_byte = sel_hi ? ~crc_q[CW-1:CW-BW] : ~crc_q[BW-1:0];
endmodule

// File: rtl/xcrc_checker.sv
module xcrc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic        page_restart,
  input logic        crc_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_byte,
  input logic [15:0] crc_q
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (!crc_ready && !out_valid));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ready && !cmd_start && !page_restart) |=> $stable(crc_q));

  p_hold_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cmd_start && !page_restart) |=>
      (out_valid && $stable(out_byte)));

  p_valid_implies_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> crc_ready);

  p_low_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_byte == ~crc_q[7:0]));
endmodule

bind xcrc_framer xcrc_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .page_restart(page_restart),
  .crc_ready(crc_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte), .crc_q(crc_q)
);

// File: tb/test_xcrc_framer.sv
module test_xcrc_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [1:0] in_kind = '0;
  logic [4:0] sp_offset = '0;
  logic       page_restart = 1'b0;
  logic       crc_ready, out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_byte;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] ref_crc;

  always #5 clk = ~clk;

  xcrc_framer i_xcrc_framer (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_code(cmd_code),
    .in_valid(in_valid), .in_byte(in_byte), .in_kind(in_kind),
    .sp_offset(sp_offset), .page_restart(page_restart), .crc_ready(crc_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  function automatic logic [15:0] upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 16'hA001;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] code);
    cmd_start = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_start = 1'b0;
    ref_crc = upd(16'h0000, code);
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] b, input logic [4:0] o);
    in_valid = 1'b1; in_kind = k; in_byte = b; sp_offset = o;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic restart();
    page_restart = 1'b1;
    @(negedge clk);
    page_restart = 1'b0;
  endtask

  task automatic drain(input logic [15:0] exp, input string req);
    chk({req, " ready"}, {15'd0, crc_ready}, 16'd1);
    chk({req, " valid lo"}, {15'd0, out_valid}, 16'd1);
    chk({req, " lo byte"}, {8'd0, out_byte}, {8'd0, ~exp[7:0]});
    repeat (2) @(negedge clk);
    chk("R10 lo held under back-pressure", {7'd0, out_valid, out_byte}, {8'd1, ~exp[7:0]});
    out_ready = 1'b1;
    @(negedge clk);
    chk({req, " hi byte"}, {7'd0, out_valid, out_byte}, {8'd1, ~exp[15:8]});
    @(negedge clk);
    chk("R10 valid drops, ready stays", {14'd0, out_valid, crc_ready}, 16'd1);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset state", {14'd0, crc_ready, out_valid}, 16'd0);

    // Scratchpad write, every start offset (R3, R4, R9, R1)
    for (int s = 0; s < 32; s++) begin
      start(8'h0F);
      send(2'd1, s[7:0], 5'd0); ref_crc = upd(ref_crc, s[7:0]);
      send(2'd1, 8'h00, 5'd0);  ref_crc = upd(ref_crc, 8'h00);
      send(2'd2, 8'h5A, 5'd0);             // status ignored in write (R3)
      send(2'd0, 8'hC3, 5'd0);             // command-tagged ignored (R3)
      restart();                           // no effect in write (R8)
      for (int o = s; o < 32; o++) begin
        d = 8'((s * 7 + o * 13 + 1) & 8'hFF);
        if (o == 31) chk("R4 no ready before last offset", {15'd0, crc_ready}, 16'd0);
        send(2'd3, d, o[4:0]);
        ref_crc = upd(ref_crc, d);
      end
      send(2'd3, 8'hEE, 5'd31);            // after ready: ignored (R9)
      drain(ref_crc, "R4 R3 R9 write crc");
    end

    // Scratchpad read, every start offset (R5)
    for (int s = 0; s < 32; s++) begin
      start(8'hAA);
      send(2'd1, 8'(s + 3), 5'd0); ref_crc = upd(ref_crc, 8'(s + 3));
      send(2'd1, 8'h01, 5'd0);     ref_crc = upd(ref_crc, 8'h01);
      send(2'd2, 8'h9F, 5'd0);     ref_crc = upd(ref_crc, 8'h9F);
      restart();                   // R8
      for (int o = s; o < 32; o++) begin
        d = 8'((o * 29) ^ s);
        send(2'd3, d, o[4:0]);
        ref_crc = upd(ref_crc, d);
      end
      drain(ref_crc, "R5 read crc");
    end

    // Extended read, three pages (R6, R7)
    start(8'hA5);
    send(2'd1, 8'h40, 5'd0); ref_crc = upd(ref_crc, 8'h40);
    send(2'd1, 8'h02, 5'd0); ref_crc = upd(ref_crc, 8'h02);
    for (int o = 0; o < 32; o++) begin
      d = 8'(o * 3 + 17);
      send(2'd3, d, o[4:0]);
      ref_crc = upd(ref_crc, d);
    end
    drain(ref_crc, "R6 first page crc");
    for (int p = 1; p < 3; p++) begin
      restart();
      chk("R7 restart drops ready", {15'd0, crc_ready}, 16'd0);
      ref_crc = 16'h0000;
      send(2'd1, 8'h77, 5'd0);             // ignored on later pages (R7)
      for (int o = 0; o < 32; o++) begin
        d = 8'(o * 11 + p * 5);
        send(2'd3, d, o[4:0]);
        ref_crc = upd(ref_crc, d);
      end
      drain(ref_crc, "R7 later page crc");
    end

    // Unknown command (R11)
    start(8'h33);
    send(2'd1, 8'h10, 5'd0);
    for (int o = 0; o < 32; o++) send(2'd3, 8'(o), o[4:0]);
    chk("R11 unknown command never ready", {14'd0, crc_ready, out_valid}, 16'd0);

    // Abort in mid-flow, then full read (R2)
    start(8'h0F);
    send(2'd1, 8'h1F, 5'd0);
    send(2'd3, 8'hAB, 5'd31);
    chk("R4 ready after offset 31", {15'd0, crc_ready}, 16'd1);
    start(8'hAA);
    chk("R2 start clears pending ready", {14'd0, crc_ready, out_valid}, 16'd0);
    send(2'd1, 8'h1E, 5'd0); ref_crc = upd(ref_crc, 8'h1E);
    send(2'd1, 8'h00, 5'd0); ref_crc = upd(ref_crc, 8'h00);
    send(2'd2, 8'h1F, 5'd0); ref_crc = upd(ref_crc, 8'h1F);
    send(2'd3, 8'h42, 5'd30); ref_crc = upd(ref_crc, 8'h42);
    send(2'd3, 8'h24, 5'd31); ref_crc = upd(ref_crc, 8'h24);
    drain(ref_crc, "R2 R1 restarted flow crc");

    // cmd_start wins over a same-cycle byte (R2)
    cmd_start = 1'b1; cmd_code = 8'h0F;
    in_valid = 1'b1; in_kind = 2'd3; in_byte = 8'h99; sp_offset = 5'd31;
    @(negedge clk);
    cmd_start = 1'b0; in_valid = 1'b0;
    ref_crc = upd(16'h0000, 8'h0F);
    chk("R2 start beats same-cycle byte", {15'd0, crc_ready}, 16'd0);
    send(2'd3, 8'h5C, 5'd31); ref_crc = upd(ref_crc, 8'h5C);
    drain(ref_crc, "R2 start priority crc");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule